// File: doc/BRIEF.md
# System Clock and Bus Reset Generator

This block turns a free-running fast oscillator of about 14.318 MHz into the bus clock of a small system. It divides the oscillator by three, which gives a bus clock of about 4.77 MHz. The bus clock is high for one oscillator period and low for the next two. The same block drives the active-high bus reset. That reset covers power-up, any low-voltage condition reported by the supply monitor, and an external reset request.

The supply monitor delivers a digital power-good flag, which is asynchronous to the oscillator. The flag is synchronized before the block uses it. While power is bad, the divider is held cleared and the bus clock stays low. Apart from the moment power is lost, the bus reset only changes at a falling edge of the bus clock. After power-good returns, or after an external request ends, the reset is held for a configurable number of bus clock cycles. The external request is also synchronized.

Top module: `sysclk_rst_gen`

## Requirements
- R1: Once running, the bus clock rises every DIV_N oscillator periods (DIV_N = 3 by default).
- R2: Each bus clock period is high for exactly one oscillator period and low for DIV_N-1 oscillator periods.
- R3: When power-good rises, the bus clock first goes high at the SYNC_STAGES+DIV_N-th oscillator rising edge after the change (5 with the default two synchronizer stages).
- R4: Whenever power-good is high, bus_rst_o changes only at an oscillator edge where sys_clk_o goes from high to low.
- R5: After power-good rises, bus_rst_o stays high through HOLD_CYC-1 bus clock falling edges and goes low at the HOLD_CYC-th falling edge.
- R6: When ext_rst_req_i rises shortly after a bus clock falling edge, bus_rst_o goes high at the next falling edge and stays high while the request is held.
- R7: When the external request is released shortly after a falling edge, bus_rst_o goes low at the HOLD_CYC-th falling edge after the release. This holds even if the request arrived while the reset was already counting out.
- R8: While power-good is low, bus_rst_o is high and sys_clk_o is low. Both take these values as soon as power-good drops, without waiting for an oscillator edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Fast oscillator clock, 50% duty |
| pwr_good_i | input | 1 | Asynchronous supply-good flag, low means low voltage or power-up |
| ext_rst_req_i | input | 1 | Asynchronous external reset request, active high |
| sys_clk_o | output | 1 | Divided bus clock, one-third high duty |
| bus_rst_o | output | 1 | Bus reset, active high, released on bus clock falling edges |

## Verification
The bench measures the bus clock waveform sample by sample against the oscillator. A divider with an off-by-one count would show a period of two or four, and a decode that is off by one state would show a two-period high time. It counts falling edges during the hold window, both from power-up and from external requests of several lengths, including a request that lands in the middle of a hold already in progress. A hold counter that is off by one, or that is not restarted by a new request, would release one edge early or late. A monitor flags any reset change that is not at a bus clock falling edge, which catches a reset register clocked on every oscillator edge. A sudden power loss during the high phase checks that the reset and the clock react at once rather than at the next edge.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

  // Next value of a counter that wraps from n-1 back to zero.
  function automatic int unsigned mod_step(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // True when the falling edge now being counted is the last one of the hold window.
  function automatic logic hold_last(int unsigned c, int unsigned h);
    return (c + 1 >= h);
  endfunction

endpackage

// File: rtl/clkrst_sync.sv
module clkrst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= RST_VAL;
        else         chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/clkrst_div.sv
module clkrst_div
  import clkrst_pkg::*;
#(
  parameter int unsigned DIV_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic clk_o
);

  localparam int unsigned CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;

  logic [CW-1:0] phase;

  // The output is registered so it carries no decode glitches.
  // It goes high on the edge that wraps the phase back to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      clk_o <= 1'b0;
    end else begin
      phase <= CW'(mod_step(32'(phase), DIV_N));
      clk_o <= (phase == CW'(DIV_N - 1));
    end
  end

endmodule

// File: rtl/clkrst_hold.sv
module clkrst_hold
  import clkrst_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt,
  input  logic req,
  output logic bus_rst
);

  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] edges;

  // This register changes only on oscillator edges where the bus clock falls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges   <= '0;
      bus_rst <= 1'b1;
    end else if (fall_evt) begin
      if (req) begin
        edges   <= '0;
        bus_rst <= 1'b1;
      end else if (bus_rst) begin
        if (hold_last(32'(edges), HOLD_CYC)) bus_rst <= 1'b0;
        else                                 edges   <= edges + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sysclk_rst_gen.sv
module sysclk_rst_gen #(
  parameter int unsigned DIV_N       = 3,
  parameter int unsigned HOLD_CYC    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic pwr_good_i,
  input  logic ext_rst_req_i,
  output logic sys_clk_o,
  output logic bus_rst_o
);

  // Named internal events, brought out for the checker.
  logic pg_ok;     // synchronized power-good, used as the internal reset
  logic req_s;     // synchronized external request
  logic clk_q;     // registered bus clock
  logic fall_evt;  // the coming oscillator edge is a bus clock falling edge

  clkrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk    (osc_clk_i),
    .arst_n (pwr_good_i),
    .d      (1'b1),
    .q      (pg_ok)
  );

  clkrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk    (osc_clk_i),
    .arst_n (pg_ok),
    .d      (ext_rst_req_i),
    .q      (req_s)
  );

  clkrst_div #(.DIV_N(DIV_N)) u_div (
    .clk   (osc_clk_i),
    .rst_n (pg_ok),
    .clk_o (clk_q)
  );

  assign fall_evt = clk_q;

  clkrst_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (osc_clk_i),
    .rst_n    (pg_ok),
    .fall_evt (fall_evt),
    .req      (req_s),
    .bus_rst  (bus_rst_o)
  );

  assign sys_clk_o = clk_q;

endmodule

// File: rtl/sysclk_rst_gen_chk.sv
module sysclk_rst_gen_chk #(
  parameter int unsigned DIV_N    = 3,
  parameter int unsigned HOLD_CYC = 4
) (
  input logic osc_clk_i,
  input logic pg_ok,
  input logic req_s,
  input logic sys_clk_o,
  input logic bus_rst_o
);

  logic        seen_rise;
  int unsigned low_run;
  int unsigned quiet_falls;

  always_ff @(posedge osc_clk_i or negedge pg_ok) begin
    if (!pg_ok) begin
      seen_rise   <= 1'b0;
      low_run     <= 0;
      quiet_falls <= 0;
    end else begin
      if (sys_clk_o) begin
        low_run   <= 0;
        seen_rise <= 1'b1;
      end else begin
        low_run <= low_run + 1;
      end
      if (req_s)                                   quiet_falls <= 0;
      else if (sys_clk_o && quiet_falls < 1000)    quiet_falls <= quiet_falls + 1;
    end
  end

  // R1: once running, the bus clock rises after exactly DIV_N-1 low oscillator periods.
  a_r1_period: assert property (@(posedge osc_clk_i) disable iff (!pg_ok)
    ($rose(sys_clk_o) && seen_rise) |-> (low_run == DIV_N - 1));

  // R2: the high phase lasts one oscillator period.
  a_r2_high_one: assert property (@(posedge osc_clk_i) disable iff (!pg_ok)
    sys_clk_o |=> !sys_clk_o);

  // R4: the reset changes only together with a bus clock falling edge.
  a_r4_rst_on_fall: assert property (@(posedge osc_clk_i) disable iff (!pg_ok)
    ($rose(bus_rst_o) || $fell(bus_rst_o)) |-> ($past(sys_clk_o) && !sys_clk_o));

  // R5: the release comes at the HOLD_CYC-th quiet falling edge.
  a_r5_hold_len: assert property (@(posedge osc_clk_i) disable iff (!pg_ok)
    $fell(bus_rst_o) |-> (quiet_falls == HOLD_CYC));

  // R6: a synchronized request seen at a falling edge leaves the reset high.
  a_r6_req_asserts: assert property (@(posedge osc_clk_i) disable iff (!pg_ok)
    (req_s && sys_clk_o) |=> bus_rst_o);

endmodule

bind sysclk_rst_gen sysclk_rst_gen_chk #(.DIV_N(DIV_N), .HOLD_CYC(HOLD_CYC)) u_chk (
  .osc_clk_i (osc_clk_i),
  .pg_ok     (pg_ok),
  .req_s     (req_s),
  .sys_clk_o (sys_clk_o),
  .bus_rst_o (bus_rst_o)
);

// File: tb/sim_sysclk_rst_gen.sv
`timescale 1ns/1ps
module sim_sysclk_rst_gen;

  localparam int OSC_PERIOD = 70;
  localparam int HOLD       = 4;
  localparam int DIVN       = 3;
  localparam int SYNC       = 2;

  // Each row: request length in falling edges, expected falling edges with reset high
  // (rising edge through release, HOLD-1 more after the request ends).
  localparam int NVEC = 4;
  localparam int VEC [NVEC][2] = '{'{1, 4}, '{2, 5}, '{3, 6}, '{6, 9}};

  logic osc_clk_i = 1'b0;
  logic pwr_good_i = 1'b0;
  logic ext_rst_req_i = 1'b0;
  logic sys_clk_o;
  logic bus_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  sysclk_rst_gen #(.DIV_N(DIVN), .HOLD_CYC(HOLD), .SYNC_STAGES(SYNC)) u0 (
    .osc_clk_i     (osc_clk_i),
    .pwr_good_i    (pwr_good_i),
    .ext_rst_req_i (ext_rst_req_i),
    .sys_clk_o     (sys_clk_o),
    .bus_rst_o     (bus_rst_o)
  );

  always #(OSC_PERIOD / 2) osc_clk_i = ~osc_clk_i;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // R4 monitor: any reset change seen with power good must coincide with a clock fall.
  logic mon_clk = 1'b0, mon_rst = 1'b1, mon_pg = 1'b0;
  always @(posedge osc_clk_i) begin
    #1;
    if (pwr_good_i && mon_pg && (bus_rst_o !== mon_rst))
      chk("R4 reset edge not on clock fall", {30'd0, mon_clk, sys_clk_o}, 2);
    mon_clk = sys_clk_o;
    mon_rst = bus_rst_o;
    mon_pg  = pwr_good_i;
  end

  initial begin
    #(OSC_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int prev;
    int last_rise;
    int lows;
    int hi;

    // Reset state with power bad (R8)
    for (int i = 0; i < 4; i++) begin
      @(posedge osc_clk_i); #1;
      chk("R8 reset high at power-up", bus_rst_o, 1);
      chk("R8 clock low at power-up", sys_clk_o, 0);
    end

    // R3: first rise at edge SYNC+DIVN after power-good rises
    @(negedge osc_clk_i);
    pwr_good_i = 1'b1;
    n = 0;
    while (n < 20) begin
      @(posedge osc_clk_i); #1;
      n++;
      if (sys_clk_o) break;
    end
    chk("R3 start latency", n, SYNC + DIVN);

    // R5: release at the HOLD-th falling edge after power-up
    n = 0;
    while (n < 50) begin
      @(negedge sys_clk_o); #1;
      n++;
      if (!bus_rst_o) break;
    end
    chk("R5 power-up hold length", n, HOLD);

    // R1 / R2: waveform shape over many oscillator periods
    prev = 0; last_rise = -1; lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge osc_clk_i); #1;
      if (sys_clk_o && !prev) begin
        if (last_rise >= 0) begin
          chk("R1 period", i - last_rise, DIVN);
          chk("R2 low time", lows, DIVN - 1);
        end
        last_rise = i;
      end
      if (prev) chk("R2 high time one period", sys_clk_o, 0);
      lows = sys_clk_o ? 0 : lows + 1;
      prev = sys_clk_o;
    end

    // R6 / R7: table of external request lengths
    for (int v = 0; v < NVEC; v++) begin
      @(negedge sys_clk_o); #5;
      ext_rst_req_i = 1'b1;
      hi = 0;
      for (int k = 0; k < VEC[v][0]; k++) begin
        @(negedge sys_clk_o); #1;
        if (k == 0) chk("R6 reset rises at first fall", bus_rst_o, 1);
        else        chk("R6 reset held during request", bus_rst_o, 1);
        if (bus_rst_o) hi++;
      end
      #4;
      ext_rst_req_i = 1'b0;
      n = 0;
      while (n < 50) begin
        @(negedge sys_clk_o); #1;
        n++;
        if (!bus_rst_o) break;
        hi++;
      end
      chk("R7 release after request", n, HOLD);
      chk("R6 R7 total high falls", hi, VEC[v][1]);
    end

    // R8: power loss during the high phase acts at once
    @(posedge sys_clk_o); #5;
    pwr_good_i = 1'b0;
    #1;
    chk("R8 reset immediate on power loss", bus_rst_o, 1);
    chk("R8 clock low immediate on power loss", sys_clk_o, 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge osc_clk_i); #1;
      chk("R8 clock held low", sys_clk_o, 0);
      chk("R8 reset held high", bus_rst_o, 1);
    end

    // R7: request arrives while the power-up hold is counting
    @(negedge osc_clk_i);
    pwr_good_i = 1'b1;
    for (int k = 0; k < 2; k++) @(negedge sys_clk_o);
    #5;
    ext_rst_req_i = 1'b1;
    @(negedge sys_clk_o); #1;
    chk("R6 reset high mid-hold", bus_rst_o, 1);
    #4;
    ext_rst_req_i = 1'b0;
    n = 0;
    while (n < 50) begin
      @(negedge sys_clk_o); #1;
      n++;
      if (!bus_rst_o) break;
    end
    chk("R7 hold restarted by request", n, HOLD);

    repeat (10) @(posedge osc_clk_i);
    finish_run();
  end

endmodule